// File: doc/BRIEF.md
# Self-Timed Four-Line Follow-the-Leader Node

This block is one device on a shared bus of four wired-OR lines that carries serial bits without any clock on the bus. When the bus rests, exactly one line is active and every device drives it. The device acting as leader sends a bit by moving the active line to a new line in two steps: first it drives the old and the new line together, then it drops the old one. Every follower copies the move in the same order and reports the bit it has decoded. The leader starts its next bit only after the old line reads released. Because every device releases the old line only after it holds the new one, the transfer waits on the slowest device and does not depend on how long each wire takes.

The leader never moves back to the line it has just left. A follower could not tell a returning leader from a slow device that still holds that line. From any resting line, the two lines that are neither the current nor the previous one are therefore the only legal destinations, and the choice between them carries one bit. A leader can pass control on by marking its last bit. After that move it becomes a follower, and another node is then told to take the lead. Bus inputs pass through a synchroniser inside the node. A follower that sees the line it just left driven again latches an error flag.

Top module: `ft4_node`

## Requirements
- R1: After reset the node drives line 0 only (line_out = 4'b0001), treats line 3 as the previous line, is not leading, and has proto_err, rx_valid and tx_ready low.
- R2: When the leader accepts a bit (tx_valid with tx_ready at a clock edge), line_out becomes the old line plus the destination line in that cycle, and the destination line alone in the next cycle.
- R3: The two candidate destinations are the lines other than the current and the previous line, taken in ascending index order. A 0 selects the lower candidate and a 1 selects the higher one. The node never drives its previous line.
- R4: tx_ready is high only while the node leads and rests. After it accepts a bit it stays low until the synchronised bus shows the old line released.
- R5: A resting follower that sees a candidate line asserted drives that line together with its current line, then the new line alone. It pulses rx_valid for exactly one cycle, with rx_bit = 1 for the higher candidate and 0 for the lower one. A leader never pulses rx_valid.
- R6: After a move a follower ignores the bus until its old line reads released. Each move therefore yields exactly one rx_valid pulse.
- R7: A resting follower that sees its previous line asserted sets proto_err, and proto_err stays set until reset. A leader never sets it.
- R8: A bit accepted with tx_last high is sent normally. After its release step the node stops leading.
- R9: A take_lead pulse on a resting follower makes it the leader, and leading goes high in the next cycle.
- R10: Bits arrive intact and in order whatever the extra input delay on each node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node clock |
| rst_n | input | 1 | Active-low reset |
| line_in | input | 4 | Wired-OR state of the four bus lines, asynchronous |
| line_out | output | 4 | Lines this node drives |
| take_lead | input | 1 | Pulse that makes a resting follower the leader |
| tx_valid | input | 1 | Leader has a bit to send |
| tx_bit | input | 1 | Bit to send |
| tx_last | input | 1 | Give up the lead after this bit |
| tx_ready | output | 1 | Leader can accept a bit |
| rx_valid | output | 1 | One-cycle pulse: follower decoded a bit |
| rx_bit | output | 1 | Decoded bit |
| leading | output | 1 | Node is currently the leader |
| proto_err | output | 1 | Sticky: previous line seen driven again |

## Verification
The assertions assume that at most one node leads at a time and that take_lead is raised only on a resting follower while the bus rests. The bench meets both conditions. It makes a node the leader only after the bus has settled, and it hands the lead over only after the old leader has given it up. Apart from the deliberate error-injection phase, the bus carries only the OR of the node outputs. Each node reads the bus through a delay of its own length, which exercises skew without breaking the one-leader assumption.

// File: rtl/ft4_node.sv
module ft4_node #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] line_in,
  output logic [3:0] line_out,
  input  logic       take_lead,
  input  logic       tx_valid,
  input  logic       tx_bit,
  input  logic       tx_last,
  output logic       tx_ready,
  output logic       rx_valid,
  output logic       rx_bit,
  output logic       leading,
  output logic       proto_err
);

  typedef enum logic [1:0] {S_REST, S_BOTH, S_WAIT} st_t;

  function automatic logic [3:0] onehot(input logic [1:0] i);
    return 4'b0001 << i;
  endfunction

  logic [SYNC_STAGES-1:0][3:0] sync_q;
  logic [3:0] sb;
  logic [1:0] cur_q, prev_q, dest_q, lo, hi;
  logic       last_q, lead_q, err_q;
  logic [3:0] drv_q;
  st_t        st_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= {SYNC_STAGES{4'b0001}};
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};

  assign sb = sync_q[SYNC_STAGES-1];

  always_comb begin
    logic found;
    found = 1'b0;
    lo = 2'd0;
    hi = 2'd0;
    for (int i = 0; i < 4; i++) begin
      if (i[1:0] != cur_q && i[1:0] != prev_q) begin
        if (!found) lo = i[1:0];
        hi = i[1:0];
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= 2'd0;
      prev_q   <= 2'd3;
      dest_q   <= 2'd0;
      drv_q    <= 4'b0001;
      st_q     <= S_REST;
      lead_q   <= 1'b0;
      last_q   <= 1'b0;
      err_q    <= 1'b0;
      rx_valid <= 1'b0;
      rx_bit   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st_q)
        S_REST: begin
          if (lead_q) begin
            if (tx_valid) begin
              dest_q <= tx_bit ? hi : lo;
              drv_q  <= onehot(cur_q) | onehot(tx_bit ? hi : lo);
              last_q <= tx_last;
              st_q   <= S_BOTH;
            end
          end else if (sb[prev_q]) begin
            err_q <= 1'b1;
          end else if (take_lead) begin
            lead_q <= 1'b1;
          end else if (sb[lo] || sb[hi]) begin
            dest_q   <= sb[lo] ? lo : hi;
            drv_q    <= onehot(cur_q) | onehot(sb[lo] ? lo : hi);
            rx_valid <= 1'b1;
            rx_bit   <= !sb[lo];
            st_q     <= S_BOTH;
          end
        end
        S_BOTH: begin
          drv_q  <= onehot(dest_q);
          prev_q <= cur_q;
          cur_q  <= dest_q;
          st_q   <= S_WAIT;
          if (last_q) begin
            lead_q <= 1'b0;
            last_q <= 1'b0;
          end
        end
        default: begin
          if (!sb[prev_q]) st_q <= S_REST;
        end
      endcase
    end
  end

  assign line_out  = drv_q;
  assign leading   = lead_q;
  assign proto_err = err_q;
  assign tx_ready  = lead_q && (st_q == S_REST);

  a_r1_never_silent: assert property (@(posedge clk) disable iff (!rst_n)
    line_out != 4'b0000);
  a_r3_no_prev_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !line_out[prev_q]);
  a_r2_keep_new: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(line_out) == 2) |=>
      ($countones(line_out) == 1 && ((line_out & $past(line_out)) == line_out)));
  a_r4_ready_at_rest: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> ($countones(line_out) == 1));
  a_r5_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r5_rx_follower: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !leading);
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

endmodule

// File: tb/ft4_node_test.sv
module ft4_node_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [3:0] out_a, out_b, out_c, inject, bus, dly_b;
  logic [2:0][3:0] dly_c;
  logic tl_a, tl_b, tl_c, tv_a, tv_b, tb_a, tb_b, tx_last_a;
  logic rdy_a, rdy_b, rdy_c, rv_a, rv_b, rv_c, rb_a, rb_b, rb_c;
  logic ld_a, ld_b, ld_c, er_a, er_b, er_c;
  int cnt_a, cnt_b, cnt_c;
  logic bit_a, bit_b, bit_c;
  int cur, prev;

  assign bus = out_a | out_b | out_c | inject;

  always_ff @(posedge clk) begin
    dly_b <= bus;
    dly_c <= {dly_c[1:0], bus};
  end

  ft4_node uut (.clk(clk), .rst_n(rst_n), .line_in(bus), .line_out(out_a),
    .take_lead(tl_a), .tx_valid(tv_a), .tx_bit(tb_a), .tx_last(tx_last_a),
    .tx_ready(rdy_a), .rx_valid(rv_a), .rx_bit(rb_a), .leading(ld_a), .proto_err(er_a));
  ft4_node node_b (.clk(clk), .rst_n(rst_n), .line_in(dly_b), .line_out(out_b),
    .take_lead(tl_b), .tx_valid(tv_b), .tx_bit(tb_b), .tx_last(1'b0),
    .tx_ready(rdy_b), .rx_valid(rv_b), .rx_bit(rb_b), .leading(ld_b), .proto_err(er_b));
  ft4_node node_c (.clk(clk), .rst_n(rst_n), .line_in(dly_c[2]), .line_out(out_c),
    .take_lead(tl_c), .tx_valid(1'b0), .tx_bit(1'b0), .tx_last(1'b0),
    .tx_ready(rdy_c), .rx_valid(rv_c), .rx_bit(rb_c), .leading(ld_c), .proto_err(er_c));

  always @(negedge clk) begin
    if (rv_a) begin cnt_a++; bit_a = rb_a; end
    if (rv_b) begin cnt_b++; bit_b = rb_b; end
    if (rv_c) begin cnt_c++; bit_c = rb_c; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dest_of(input int c, input int p, input bit b);
    int lo = -1, hi = -1;
    for (int i = 0; i < 4; i++)
      if (i != c && i != p) begin
        if (lo < 0) lo = i;
        hi = i;
      end
    return b ? hi : lo;
  endfunction

  task automatic send_a(input bit b, input bit last);
    int d = dest_of(cur, prev, b);
    int pa = cnt_a, pb = cnt_b, pc = cnt_c;
    @(negedge clk);
    while (!rdy_a) @(negedge clk);
    tv_a = 1'b1; tb_a = b; tx_last_a = last;
    @(posedge clk);
    @(negedge clk);
    tv_a = 1'b0; tx_last_a = 1'b0;
    check(rdy_a == 1'b0, "R4 busy after accept", rdy_a, 0);
    check(out_a == ((4'b1 << cur) | (4'b1 << d)), "R2 R3 both lines", out_a, (4'b1 << cur) | (4'b1 << d));
    @(negedge clk);
    check(out_a == (4'b1 << d), "R2 new line only", out_a, 4'b1 << d);
    repeat (30) @(negedge clk);
    prev = cur; cur = d;
    check(bus == (4'b1 << cur), "R10 bus settled", bus, 4'b1 << cur);
    check(cnt_b == pb + 1 && bit_b == b, "R5 R6 rx at B", {cnt_b - pb, bit_b}, {1, b});
    check(cnt_c == pc + 1 && bit_c == b, "R5 R10 rx at C", {cnt_c - pc, bit_c}, {1, b});
    check(cnt_a == pa, "R5 leader silent", cnt_a - pa, 0);
  endtask

  task automatic send_b(input bit b);
    int d = dest_of(cur, prev, b);
    int pa = cnt_a, pc = cnt_c;
    @(negedge clk);
    while (!rdy_b) @(negedge clk);
    tv_b = 1'b1; tb_b = b;
    @(posedge clk);
    @(negedge clk);
    tv_b = 1'b0;
    repeat (30) @(negedge clk);
    prev = cur; cur = d;
    check(bus == (4'b1 << cur), "R8 R10 bus after handoff", bus, 4'b1 << cur);
    check(cnt_a == pa + 1 && bit_a == b, "R8 rx at old leader", {cnt_a - pa, bit_a}, {1, b});
    check(cnt_c == pc + 1 && bit_c == b, "R10 rx at C", {cnt_c - pc, bit_c}, {1, b});
  endtask

  initial begin
    inject = 4'b0; dly_b = 4'b0001; dly_c = {3{4'b0001}};
    tl_a = 0; tl_b = 0; tl_c = 0; tv_a = 0; tv_b = 0; tb_a = 0; tb_b = 0; tx_last_a = 0;
    cnt_a = 0; cnt_b = 0; cnt_c = 0; bit_a = 0; bit_b = 0; bit_c = 0;
    cur = 0; prev = 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(out_a == 4'b0001 && out_b == 4'b0001 && out_c == 4'b0001, "R1 idle line", out_a | out_b | out_c, 1);
    check(!ld_a && !ld_b && !ld_c && !rdy_a, "R1 no leader", {ld_a, ld_b, ld_c, rdy_a}, 0);
    check(!er_a && !er_b && !er_c && cnt_a + cnt_b + cnt_c == 0, "R1 quiet", {er_a, er_b, er_c}, 0);

    tl_a = 1'b1; @(negedge clk); tl_a = 1'b0;
    check(ld_a && rdy_a, "R9 take lead", {ld_a, rdy_a}, 3);

    for (int p = 0; p < 64; p++)
      for (int k = 0; k < 6; k++)
        send_a(p[k], 1'b0);

    send_a(1'b1, 1'b1);
    check(!ld_a && !rdy_a, "R8 lead given up", {ld_a, rdy_a}, 0);
    tl_b = 1'b1; @(negedge clk); tl_b = 1'b0;
    check(ld_b && rdy_b, "R9 B leads", {ld_b, rdy_b}, 3);
    for (int k = 0; k < 8; k++) send_b(k[0] ^ k[2]);

    repeat (5) @(negedge clk);
    inject = 4'b1 << prev;
    repeat (8) @(negedge clk);
    inject = 4'b0;
    repeat (10) @(negedge clk);
    check(er_a && er_c, "R7 error latched", {er_a, er_c}, 3);
    check(!er_b, "R7 leader no error", er_b, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule